// File: doc/BRIEF.md
# TDM Transmit Time-Slot Mapper

This block produces the serial transmit side of a time-division multiplexed line. It walks every bit position of a frame, one bit per clock. For each position it looks up which logical channel owns the current slot and whether that bit of the slot is enabled. When the bit is enabled, the block takes the next bit from that channel's source and drives it onto the line. Bits that are masked, and slots that no channel owns, are left undriven: the output-enable meant for an external tri-state pad driver is low for them. A channel can own any set of slots. Its bit stream is packed in order into the enabled bit positions of those slots, so a slot with some mask bits cleared carries less than 64 kbit/s of that channel.

The transmit assignment table is written one slot at a time through a simple register port. Writes go to a shadow copy. The shadow copy is moved into the working copy at the frame boundary, together with the frame mode. The frame mode selects 24, 32, 64 or 128 slots per frame. Each channel source is a ready/valid bit input. When a channel has no bit ready at its bit time, the line carries an idle 1 and the channel's underrun flag is raised.

Top module: `tdm_tx_mapper`

## Requirements
- R1: The frame length follows the working mode: code 0 gives 24 slots, code 1 gives 32, code 2 gives 64 and code 3 gives 128, each slot being 8 bits. `tx_frame` is high exactly during the bit time of bit 0 of slot 0.
- R2: Bit positions are sent one per clock, with slots in ascending order and, inside a slot, bit 0 first up to bit 7.
- R3: Any slot may be given to any channel, and a channel may own several slots. Each channel's bits appear on the line in the order its source supplies them, continuously across that channel's enabled positions.
- R4: A mask bit at 0 disables the matching bit position of the slot. During that bit time `tx_oe` and `tx_data` are low, and no bit is requested from the channel. For example, mask 0xFE removes bit 0 and mask 0xFD removes bit 1.
- R5: A slot whose used flag is 0 is not driven: `tx_oe` and `tx_data` stay low for all 8 of its bits, and no channel is requested.
- R6: The request `ch_req[c]` for an enabled position is high in the clock before that position's bit time. At most one request is high at a time. A bit is taken when request and `ch_valid[c]` are both high, and it appears on `tx_data` with `tx_oe` high at the next clock edge.
- R7: If `ch_valid[c]` is low while the channel is requested, that bit time carries `tx_data`=1 with `tx_oe`=1, and `underrun[c]` is high for that single bit time. No source bit is consumed.
- R8: Table writes and changes of `frame_mode` take effect from the first bit of the next frame. The frame in progress keeps the assignment it started with.
- R9: During and after reset, all outputs are low and every slot is unassigned, so the first frame after reset is entirely undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bit time per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_mode | input | 2 | Requested frame mode, taken at the frame boundary |
| cfg_we | input | 1 | Write strobe for the shadow table |
| cfg_slot | input | 7 | Slot number written |
| cfg_used | input | 1 | Slot owned by a channel |
| cfg_chan | input | CHW | Owning channel |
| cfg_mask | input | 8 | Per-bit enable mask for the slot |
| ch_req | output | NCH | Per-channel bit request (ready) |
| ch_valid | input | NCH | Per-channel bit available |
| ch_data | input | NCH | Per-channel bit value |
| tx_data | output | 1 | Line data bit |
| tx_oe | output | 1 | Output-enable for the pad driver |
| tx_frame | output | 1 | First bit of frame marker |
| underrun | output | NCH | Per-channel underrun pulse |

## Verification
A position is looked up, and its request raised, in one clock. Its line bit, output-enable, underrun flag and frame marker all appear one edge later. Table writes appear from the first bit after the current frame ends. The bench builds the expected line contents for a whole frame ahead of that frame and queues them. A monitor starts popping at the `tx_frame` pulse and compares one queued bit per falling edge, so every comparison falls in the bit time the requirements assign to it. The bench's channel sources advance only on an accepted request, which makes any early, late or spurious request show up as shifted data.

// File: rtl/tdm_map_pkg.sv
package tdm_map_pkg;

    localparam int unsigned MAX_SLOTS  = 128;
    localparam int unsigned SLOT_BITS  = 8;
    localparam int unsigned SLOT_IDX_W = $clog2(MAX_SLOTS);
    localparam int unsigned BIT_IDX_W  = $clog2(SLOT_BITS);

    typedef enum logic [1:0] {
        MODE_24 = 2'd0,
        MODE_32 = 2'd1,
        MODE_64 = 2'd2,
        MODE_128 = 2'd3
    } frame_mode_e;

    // Slots per frame for a mode code.
    function automatic logic [SLOT_IDX_W:0] slots_in_mode(input logic [1:0] m);
        case (m)
            MODE_24: return (SLOT_IDX_W+1)'(24);
            MODE_32: return (SLOT_IDX_W+1)'(32);
            MODE_64: return (SLOT_IDX_W+1)'(64);
            default: return (SLOT_IDX_W+1)'(128);
        endcase
    endfunction

endpackage

// File: rtl/tdm_bit_counter.sv
module tdm_bit_counter
    import tdm_map_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            mode_i,
    output logic [SLOT_IDX_W-1:0] slot_o,
    output logic [BIT_IDX_W-1:0]  bit_o,
    output logic                  first_o,
    output logic                  last_o
);

    typedef struct packed {
        logic [SLOT_IDX_W-1:0] slot;
        logic [BIT_IDX_W-1:0]  bitp;
        logic [1:0]            mode;
    } cnt_t;

    localparam logic [BIT_IDX_W-1:0] BIT_LAST = BIT_IDX_W'(SLOT_BITS - 1);

    cnt_t                  cnt_d, cnt_q;
    logic [SLOT_IDX_W:0]   nslots;
    logic                  last;

    always_comb begin
        nslots = slots_in_mode(cnt_q.mode);
        last   = (cnt_q.bitp == BIT_LAST) &&
                 ({1'b0, cnt_q.slot} == nslots - 1'b1);
        cnt_d  = cnt_q;
        if (cnt_q.bitp == BIT_LAST) begin
            cnt_d.bitp = '0;
            cnt_d.slot = last ? '0 : cnt_q.slot + 1'b1;
        end else begin
            cnt_d.bitp = cnt_q.bitp + 1'b1;
        end
        if (last) begin
            cnt_d.mode = mode_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '{slot: '0, bitp: '0, mode: MODE_24};
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign slot_o  = cnt_q.slot;
    assign bit_o   = cnt_q.bitp;
    assign first_o = (cnt_q.slot == '0) && (cnt_q.bitp == '0);
    assign last_o  = last;

    // R1: the slot pointer never leaves the frame of the working mode
    a_r1_slot_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, cnt_q.slot} < slots_in_mode(cnt_q.mode));

    // R1: after the last position the walk restarts at slot 0 bit 0
    a_r1_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> (cnt_q.slot == '0) && (cnt_q.bitp == '0));

    // R2: inside a slot bits advance by one each clock
    a_r2_bit_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q.bitp != BIT_LAST) |=>
            (cnt_q.bitp == BIT_IDX_W'($past(cnt_q.bitp) + 1'b1)) &&
            $stable(cnt_q.slot));

endmodule

// File: rtl/tdm_slot_table.sv
module tdm_slot_table
    import tdm_map_pkg::*;
#(
    parameter int unsigned CHW = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [SLOT_IDX_W-1:0] wr_slot_i,
    input  logic                  wr_used_i,
    input  logic [CHW-1:0]        wr_chan_i,
    input  logic [SLOT_BITS-1:0]  wr_mask_i,
    input  logic                  commit_i,
    input  logic [SLOT_IDX_W-1:0] rd_slot_i,
    output logic                  rd_used_o,
    output logic [CHW-1:0]        rd_chan_o,
    output logic [SLOT_BITS-1:0]  rd_mask_o
);

    typedef struct packed {
        logic                 used;
        logic [CHW-1:0]       chan;
        logic [SLOT_BITS-1:0] mask;
    } ent_t;

    typedef struct packed {
        ent_t [MAX_SLOTS-1:0] shadow;
        ent_t [MAX_SLOTS-1:0] active;
    } tab_t;

    tab_t tab_d, tab_q;
    ent_t rd_ent;

    always_comb begin
        tab_d = tab_q;
        if (commit_i) begin
            tab_d.active = tab_q.shadow;
        end
        if (wr_en_i) begin
            tab_d.shadow[wr_slot_i] = '{used: wr_used_i, chan: wr_chan_i, mask: wr_mask_i};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tab_q <= '0;
        end else begin
            tab_q <= tab_d;
        end
    end

    assign rd_ent    = tab_q.active[rd_slot_i];
    assign rd_used_o = rd_ent.used;
    assign rd_chan_o = rd_ent.chan;
    assign rd_mask_o = rd_ent.mask;

    // R8: the working table only changes on a frame boundary
    a_r8_active_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(tab_q.active));

endmodule

// File: rtl/tdm_tx_stage.sv
module tdm_tx_stage
    import tdm_map_pkg::*;
#(
    parameter int unsigned NCH = 8,
    parameter int unsigned CHW = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 used_i,
    input  logic [CHW-1:0]       chan_i,
    input  logic [SLOT_BITS-1:0] mask_i,
    input  logic [BIT_IDX_W-1:0] bit_i,
    input  logic                 first_i,
    input  logic [NCH-1:0]       ch_valid_i,
    input  logic [NCH-1:0]       ch_data_i,
    output logic [NCH-1:0]       ch_req_o,
    output logic                 tx_data_o,
    output logic                 tx_oe_o,
    output logic                 tx_frame_o,
    output logic [NCH-1:0]       underrun_o
);

    typedef struct packed {
        logic           data;
        logic           oe;
        logic           frame;
        logic [NCH-1:0] und;
    } out_t;

    out_t out_d, out_q;
    logic bit_en;

    always_comb begin
        bit_en   = used_i && mask_i[bit_i] && (int'(chan_i) < NCH);
        ch_req_o = '0;
        out_d    = '0;
        out_d.frame = first_i;
        if (bit_en) begin
            ch_req_o[chan_i] = 1'b1;
            out_d.oe = 1'b1;
            if (ch_valid_i[chan_i]) begin
                out_d.data = ch_data_i[chan_i];
            end else begin
                out_d.data        = 1'b1;
                out_d.und[chan_i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign tx_data_o  = out_q.data;
    assign tx_oe_o    = out_q.oe;
    assign tx_frame_o = out_q.frame;
    assign underrun_o = out_q.und;

    // R6: never more than one channel asked at once
    a_r6_single_request: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_req_o));

    // R4, R5: an undriven bit time is low and flags nothing
    a_r4_quiet_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
        !out_q.oe |-> !out_q.data && (out_q.und == '0));

    // R7: an underrun bit is driven as idle one, one channel at a time
    a_r7_underrun_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q.und != '0) |-> out_q.oe && out_q.data && $onehot0(out_q.und));

endmodule

// File: rtl/tdm_tx_mapper.sv
module tdm_tx_mapper
    import tdm_map_pkg::*;
#(
    parameter int unsigned NCH = 8,
    parameter int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            frame_mode,
    input  logic                  cfg_we,
    input  logic [SLOT_IDX_W-1:0] cfg_slot,
    input  logic                  cfg_used,
    input  logic [CHW-1:0]        cfg_chan,
    input  logic [SLOT_BITS-1:0]  cfg_mask,
    output logic [NCH-1:0]        ch_req,
    input  logic [NCH-1:0]        ch_valid,
    input  logic [NCH-1:0]        ch_data,
    output logic                  tx_data,
    output logic                  tx_oe,
    output logic                  tx_frame,
    output logic [NCH-1:0]        underrun
);

    logic [SLOT_IDX_W-1:0] pos_slot;
    logic [BIT_IDX_W-1:0]  pos_bit;
    logic                  pos_first;
    logic                  pos_last;
    logic                  ent_used;
    logic [CHW-1:0]        ent_chan;
    logic [SLOT_BITS-1:0]  ent_mask;

    tdm_bit_counter u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (frame_mode),
        .slot_o  (pos_slot),
        .bit_o   (pos_bit),
        .first_o (pos_first),
        .last_o  (pos_last)
    );

    tdm_slot_table #(.CHW(CHW)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (cfg_we),
        .wr_slot_i (cfg_slot),
        .wr_used_i (cfg_used),
        .wr_chan_i (cfg_chan),
        .wr_mask_i (cfg_mask),
        .commit_i  (pos_last),
        .rd_slot_i (pos_slot),
        .rd_used_o (ent_used),
        .rd_chan_o (ent_chan),
        .rd_mask_o (ent_mask)
    );

    tdm_tx_stage #(.NCH(NCH), .CHW(CHW)) u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .used_i     (ent_used),
        .chan_i     (ent_chan),
        .mask_i     (ent_mask),
        .bit_i      (pos_bit),
        .first_i    (pos_first),
        .ch_valid_i (ch_valid),
        .ch_data_i  (ch_data),
        .ch_req_o   (ch_req),
        .tx_data_o  (tx_data),
        .tx_oe_o    (tx_oe),
        .tx_frame_o (tx_frame),
        .underrun_o (underrun)
    );

    // R6: every driven bit time follows a request in the clock before
    a_r6_bit_after_request: assert property (@(posedge clk) disable iff (!rst_n)
        tx_oe |-> $past(|ch_req));

endmodule

// File: tb/test_tdm_tx_mapper.sv
module test_tdm_tx_mapper;
    import tdm_map_pkg::*;

    localparam int NCH = 8;
    localparam int CHW = 3;

    logic                  clk = 1'b0;
    logic                  rst_n;
    logic [1:0]            frame_mode;
    logic                  cfg_we;
    logic [SLOT_IDX_W-1:0] cfg_slot;
    logic                  cfg_used;
    logic [CHW-1:0]        cfg_chan;
    logic [7:0]            cfg_mask;
    logic [NCH-1:0]        ch_req;
    logic [NCH-1:0]        ch_valid;
    logic [NCH-1:0]        ch_data;
    logic                  tx_data;
    logic                  tx_oe;
    logic                  tx_frame;
    logic [NCH-1:0]        underrun;

    always #10 clk = ~clk;

    tdm_tx_mapper #(.NCH(NCH)) i_tdm_tx_mapper (
        .clk(clk), .rst_n(rst_n), .frame_mode(frame_mode),
        .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_used(cfg_used),
        .cfg_chan(cfg_chan), .cfg_mask(cfg_mask),
        .ch_req(ch_req), .ch_valid(ch_valid), .ch_data(ch_data),
        .tx_data(tx_data), .tx_oe(tx_oe), .tx_frame(tx_frame),
        .underrun(underrun)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    function automatic logic pat(input int c, input int i);
        logic [31:0] k;
        k = 32'h9E37_79B9;
        return k[(i * 5 + c * 11) % 32];
    endfunction

    // Channel sources: a bit is consumed on request and valid (R6)
    logic [NCH-1:0] valid_en;
    int src_cnt [NCH];
    assign ch_valid = valid_en;
    always_comb begin
        for (int c = 0; c < NCH; c++) ch_data[c] = pat(c, src_cnt[c]);
    end
    always @(posedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            if (!rst_n) src_cnt[c] <= 0;
            else if (ch_req[c] && ch_valid[c]) src_cnt[c] <= src_cnt[c] + 1;
        end
    end

    // Bench copy of the table and expected stream
    typedef struct {
        logic           oe;
        logic           data;
        logic           frame;
        logic [NCH-1:0] und;
        string          tag;
    } exp_t;
    exp_t exq[$];
    logic       m_used [MAX_SLOTS];
    int         m_ch   [MAX_SLOTS];
    logic [7:0] m_mask [MAX_SLOTS];
    int         exp_cnt [NCH];

    task automatic cfg_write(input int s, input logic u, input int c, input logic [7:0] m);
        cfg_we   = 1'b1;
        cfg_slot = SLOT_IDX_W'(s);
        cfg_used = u;
        cfg_chan = CHW'(c);
        cfg_mask = m;
        m_used[s] = u; m_ch[s] = c; m_mask[s] = m;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Expected line bits for one whole frame (R1, R2, R3, R4, R5, R7)
    task automatic plan_frame(input int n);
        for (int s = 0; s < n; s++) begin
            for (int b = 0; b < 8; b++) begin
                exp_t it;
                it.frame = (s == 0 && b == 0);
                it.und   = '0;
                if (m_used[s] && m_mask[s][b]) begin
                    int c;
                    c = m_ch[s];
                    it.oe = 1'b1;
                    if (valid_en[c]) begin
                        it.data = pat(c, exp_cnt[c]);
                        exp_cnt[c]++;
                        it.tag = "R3";
                    end else begin
                        it.data = 1'b1;
                        it.und[c] = 1'b1;
                        it.tag = "R7";
                    end
                end else begin
                    it.oe = 1'b0;
                    it.data = 1'b0;
                    it.tag = m_used[s] ? "R4" : "R5";
                end
                exq.push_back(it);
            end
        end
    endtask

    task automatic wait_frame();
        do @(negedge clk); while (!tx_frame);
    endtask

    task automatic check_bit(input string tag, input logic [NCH+1:0] act, input logic [NCH+1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s {oe,data,underrun} actual %b expected %b", tag, act, exp);
        end
    endtask

    // Monitor: one expected bit per falling edge from the frame pulse on
    bit started = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!started && tx_frame && exq.size() > 0) started = 1;
            if (started) begin
                if (exq.size() == 0) begin
                    started = 0;
                end else begin
                    exp_t it;
                    it = exq.pop_front();
                    // R2 order, R6 timing and R8 frame-aligned table all show here
                    check_bit(it.tag, {tx_oe, tx_data, underrun}, {it.oe, it.data, it.und});
                    checks++;
                    if (tx_frame !== it.frame) begin
                        errors++;
                        $display("FAIL R1 tx_frame actual %b expected %b", tx_frame, it.frame);
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired, queue %0d", exq.size());
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < MAX_SLOTS; s++) begin
            m_used[s] = 1'b0; m_ch[s] = 0; m_mask[s] = 8'hFF;
        end
        for (int c = 0; c < NCH; c++) exp_cnt[c] = 0;
        rst_n = 1'b0; frame_mode = MODE_24; cfg_we = 1'b0;
        cfg_slot = '0; cfg_used = 1'b0; cfg_chan = '0; cfg_mask = '0;
        valid_en = 8'hFB;   // channel 2 never ready
        repeat (3) @(negedge clk);
        // R9: outputs low in reset
        check_bit("R9", {tx_oe, tx_data, underrun}, '0);
        checks++;
        if (tx_frame !== 1'b0) begin
            errors++;
            $display("FAIL R9 tx_frame actual %b expected 0", tx_frame);
        end
        rst_n = 1'b1;
        wait_frame();
        // R9: empty table, first frame undriven
        check_bit("R9", {tx_oe, tx_data, underrun}, '0);

        // Frame 1: 24 slots; masks FE and FD on channel 5 (R4), underrun on ch 2 (R7)
        cfg_write(0, 1'b1, 1, 8'hFF);
        cfg_write(2, 1'b1, 5, 8'hFE);
        cfg_write(3, 1'b1, 5, 8'hFD);
        cfg_write(7, 1'b1, 2, 8'hFF);
        cfg_write(10, 1'b1, 1, 8'h81);
        cfg_write(23, 1'b1, 3, 8'h0F);
        frame_mode = MODE_24;
        plan_frame(24);

        wait_frame();
        // Frame 2: 32 slots; written mid-frame 1, must not alter frame 1 (R8)
        cfg_write(31, 1'b1, 6, 8'hFF);
        cfg_write(2, 1'b0, 5, 8'hFF);
        frame_mode = MODE_32;
        plan_frame(32);

        wait_frame();
        // Frame 3: 64 slots
        cfg_write(63, 1'b1, 7, 8'hAA);
        cfg_write(40, 1'b1, 0, 8'hFF);
        frame_mode = MODE_64;
        plan_frame(64);

        wait_frame();
        // Frame 4: 128 slots
        cfg_write(127, 1'b1, 4, 8'h55);
        cfg_write(64, 1'b1, 0, 8'h80);
        frame_mode = MODE_128;
        plan_frame(128);

        wait_frame();
        // Frame 5: back to 24 slots; slot 100 lies outside the frame (R1)
        cfg_write(100, 1'b1, 6, 8'hFF);
        cfg_write(3, 1'b0, 5, 8'hFF);
        frame_mode = MODE_24;
        plan_frame(24);

        while (exq.size() > 0 || started) @(negedge clk);
        repeat (4) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule